// File: doc/BRIEF.md
# Modular-Arithmetic Command Front-End

This block sits between a host register bus and a modular-arithmetic engine. The host programs operand descriptors over a 32-bit register bus. Each descriptor is a word base address plus a length field. The host then writes a command word that selects the operation. Every descriptor write lands in a shadow register. The shadow set is copied into an active set at the moment an operation launches, so the host can prepare the next operation while the current one runs.

On launch the block sends the engine a one-cycle start pulse, the opcode, the exponent flag and the active descriptors. It then holds a busy flag until the engine reports done or the host aborts. A modular-inverse helper can hold off a launch: while the helper is busy, a command waits as pending and starts once the helper goes idle. An abort is never held back. Status flags for overflow, busy and command error, together with a maskable interrupt, report progress to the host.

Top module: `mae_cmd_front`

## Requirements
- R1: After reset every readable register returns 0, and eng_start, eng_abort and irq are low.
- R2: The operand descriptors sit at word addresses 2, 3 and 4, with the base in bits [9:0] and the count minus 1 in bits [23:16]. The exponent descriptor sits at address 5, with the base in bits [10:0] and the bit count minus 2 in bits [28:16]. Reads return the stored fields, and all other bits read as 0.
- R3: A write to address 1 is a command. Bits [1:0] hold the opcode (0 no-op, 1 multiply, 2 multiply-next, 3 three-operand multiply) and bit 2 requests exponentiation. A non-zero command issued while the block is idle, the helper is idle and all bases are even gives a one-cycle eng_start on the next cycle, with busy (status bit 1) set and eng_op/eng_exp carrying the command. A command of 0 does nothing.
- R4: The active descriptor outputs take the shadow values held just before the launch edge. Descriptor writes at any other time, including while busy or in the launch cycle itself, leave the active outputs unchanged until the next launch.
- R5: If inv_busy is high when a command is written, the command waits. eng_start and busy rise on the edge after the first cycle in which inv_busy is sampled low.
- R6: A command issued while any of the four shadow bases has bit 0 set does not launch, and it sets the command-error flag (status bit 2).
- R7: A command issued while busy or while another command is pending does not launch, sets the command-error flag, and leaves the running operation unchanged.
- R8: A command with bit 5 set is an abort, and its other bits are ignored. It gives a one-cycle eng_abort on the next cycle, clears busy and drops any pending command, whatever inv_busy is doing.
- R9: eng_done while busy clears busy on the next cycle and sets the sticky overflow flag (status bit 0) when eng_ovf is high. eng_done while idle has no effect.
- R10: Writing 1 to status bit 0 or bit 2 clears that flag. A flag set in the same cycle wins over the clear.
- R11: The interrupt flag (address 6, bit 0) is set whenever busy falls and is cleared by writing 1, with a set winning over a clear. irq equals that flag ANDed with the enable bit (address 7, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| inv_busy | input | 1 | Modular-inverse helper busy |
| eng_done | input | 1 | Engine finished the operation |
| eng_ovf | input | 1 | Engine overflow, qualified by eng_done |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_op | output | 2 | Active opcode |
| eng_exp | output | 1 | Active exponentiation request |
| eng_a_base | output | 10 | Active first operand base |
| eng_a_len | output | 8 | Active first operand count minus 1 |
| eng_b_base | output | 10 | Active second operand base |
| eng_b_len | output | 8 | Active second operand count minus 1 |
| eng_c_base | output | 10 | Active third operand base |
| eng_c_len | output | 8 | Active third operand pass count minus 1 |
| eng_e_base | output | 11 | Active exponent/result base |
| eng_e_bits | output | 13 | Active exponent bit count minus 2 |
| irq | output | 1 | Masked completion interrupt |

## Verification
Two collisions get the most attention. The first is a shadow descriptor write in the same cycle as a deferred launch. The bench drops inv_busy and writes a new second-operand base on the same edge, then expects the engine to receive the old base while a read of the register shows the new one. The second is eng_done with eng_ovf landing in the same cycle as a host write that clears the overflow flag. Here the status read afterwards must show overflow still set. A behavioural model runs alongside and compares every output and the read data on every cycle.

// File: rtl/mae_pkg.sv
package mae_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_AW  = 3;
    localparam int OP_W    = 2;
    localparam int BASE_W  = 10;
    localparam int LEN_W   = 8;
    localparam int EBASE_W = 11;
    localparam int EBITS_W = 13;
    localparam int FLD_LSB = 16;
    localparam int N_OPND  = 3;

    localparam logic [REG_AW-1:0] RA_STS = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_CMD = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_DA  = REG_AW'(2);
    localparam logic [REG_AW-1:0] RA_DB  = REG_AW'(3);
    localparam logic [REG_AW-1:0] RA_DC  = REG_AW'(4);
    localparam logic [REG_AW-1:0] RA_DE  = REG_AW'(5);
    localparam logic [REG_AW-1:0] RA_IST = REG_AW'(6);
    localparam logic [REG_AW-1:0] RA_IEN = REG_AW'(7);

    localparam int CMD_EXP_BIT   = 2;
    localparam int CMD_ABORT_BIT = 5;
    localparam int STS_OVF_BIT   = 0;
    localparam int STS_BUSY_BIT  = 1;
    localparam int STS_ERR_BIT   = 2;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } opnd_t;

    typedef struct packed {
        logic [EBASE_W-1:0] base;
        logic [EBITS_W-1:0] bits;
    } expd_t;

    typedef struct packed {
        opnd_t a;
        opnd_t b;
        opnd_t c;
        expd_t e;
    } desc_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic            exp;
    } cmd_t;

    localparam int DESC_W = $bits(desc_t);

    function automatic logic [DATA_W-1:0] pack_opnd(input opnd_t o);
        logic [DATA_W-1:0] r;
        r = '0;
        r[BASE_W-1:0]         = o.base;
        r[FLD_LSB +: LEN_W]   = o.len;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_expd(input expd_t x);
        logic [DATA_W-1:0] r;
        r = '0;
        r[EBASE_W-1:0]        = x.base;
        r[FLD_LSB +: EBITS_W] = x.bits;
        return r;
    endfunction

endpackage

// File: rtl/mae_shadow.sv
module mae_shadow
    import mae_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output desc_t             shadow,
    output logic              irq_en
);

    typedef struct packed {
        opnd_t [N_OPND-1:0] opnd;
        expd_t              e;
        logic               ien;
    } shd_state_t;

    shd_state_t d, q;
    logic [N_OPND-1:0] opnd_sel;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar g = 0; g < N_OPND; g++) begin : g_sel
        assign opnd_sel[g] = wr_en && (addr == (RA_DA + REG_AW'(g)));
    end

    always_comb begin
        d = q;
        for (int i = 0; i < N_OPND; i++) begin
            if (opnd_sel[i]) begin
                d.opnd[i].base = wdata[BASE_W-1:0];
                d.opnd[i].len  = wdata[FLD_LSB +: LEN_W];
            end
        end
        if (wr_en && addr == RA_DE) begin
            d.e.base = wdata[EBASE_W-1:0];
            d.e.bits = wdata[FLD_LSB +: EBITS_W];
        end
        if (wr_en && addr == RA_IEN) begin
            d.ien = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign shadow = '{a: q.opnd[0], b: q.opnd[1], c: q.opnd[2], e: q.e};
    assign irq_en = q.ien;

endmodule

// File: rtl/mae_seq.sv
module mae_seq
    import mae_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              sts_wr,
    input  logic              ist_wr,
    input  logic [DATA_W-1:0] wdata,
    input  desc_t             shadow,
    input  logic              inv_busy,
    input  logic              eng_done,
    input  logic              eng_ovf,
    output desc_t             active,
    output cmd_t              act_cmd,
    output logic              start,
    output logic              abort,
    output logic              busy,
    output logic              err,
    output logic              ovf,
    output logic              irq_st
);

    typedef struct packed {
        logic  busy;
        logic  pend;
        logic  err;
        logic  ovf;
        logic  ist;
        logic  start;
        logic  abort;
        cmd_t  pcmd;
        cmd_t  acmd;
        desc_t act;
    } seq_state_t;

    seq_state_t d, q;
    logic unused_wdata;

    logic abort_req, cmd_nz, odd_base, launch, busy_fall, err_set, ovf_set;
    cmd_t new_cmd, launch_cmd;

    assign unused_wdata = ^wdata;

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.abort    = 1'b0;
        launch     = 1'b0;
        launch_cmd = q.pcmd;
        busy_fall  = 1'b0;
        err_set    = 1'b0;
        ovf_set    = 1'b0;

        new_cmd.op  = wdata[OP_W-1:0];
        new_cmd.exp = wdata[CMD_EXP_BIT];
        abort_req   = cmd_wr && wdata[CMD_ABORT_BIT];
        cmd_nz      = cmd_wr && !wdata[CMD_ABORT_BIT] &&
                      ((new_cmd.op != '0) || new_cmd.exp);
        odd_base    = shadow.a.base[0] | shadow.b.base[0] |
                      shadow.c.base[0] | shadow.e.base[0];

        if (abort_req) begin
            d.abort = 1'b1;
            d.pend  = 1'b0;
            if (q.busy) begin
                d.busy    = 1'b0;
                busy_fall = 1'b1;
            end
        end else begin
            if (q.busy && eng_done) begin
                d.busy    = 1'b0;
                busy_fall = 1'b1;
                ovf_set   = eng_ovf;
            end
            if (q.pend && !inv_busy) begin
                launch     = 1'b1;
                launch_cmd = q.pcmd;
                d.pend     = 1'b0;
            end
            if (cmd_nz) begin
                if (q.busy || q.pend || odd_base) begin
                    err_set = 1'b1;
                end else if (inv_busy) begin
                    d.pend = 1'b1;
                    d.pcmd = new_cmd;
                end else begin
                    launch     = 1'b1;
                    launch_cmd = new_cmd;
                end
            end
        end

        if (launch) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
            d.act   = shadow;
            d.acmd  = launch_cmd;
        end

        if (sts_wr && wdata[STS_OVF_BIT]) d.ovf = 1'b0;
        if (sts_wr && wdata[STS_ERR_BIT]) d.err = 1'b0;
        if (ovf_set)                      d.ovf = 1'b1;
        if (err_set)                      d.err = 1'b1;

        if (ist_wr && wdata[0]) d.ist = 1'b0;
        if (busy_fall)          d.ist = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.act;
    assign act_cmd = q.acmd;
    assign start   = q.start;
    assign abort   = q.abort;
    assign busy    = q.busy;
    assign err     = q.err;
    assign ovf     = q.ovf;
    assign irq_st  = q.ist;

endmodule

// File: rtl/mae_cmd_front.sv
module mae_cmd_front
    import mae_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               inv_busy,
    input  logic               eng_done,
    input  logic               eng_ovf,
    output logic               eng_start,
    output logic               eng_abort,
    output logic [OP_W-1:0]    eng_op,
    output logic               eng_exp,
    output logic [BASE_W-1:0]  eng_a_base,
    output logic [LEN_W-1:0]   eng_a_len,
    output logic [BASE_W-1:0]  eng_b_base,
    output logic [LEN_W-1:0]   eng_b_len,
    output logic [BASE_W-1:0]  eng_c_base,
    output logic [LEN_W-1:0]   eng_c_len,
    output logic [EBASE_W-1:0] eng_e_base,
    output logic [EBITS_W-1:0] eng_e_bits,
    output logic               irq
);

    desc_t shadow;
    desc_t act_desc;
    cmd_t  act_cmd;
    logic  irq_en;
    logic  st_busy, st_err, st_ovf, st_ist;

    mae_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .shadow (shadow),
        .irq_en (irq_en)
    );

    mae_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (bus_wr && bus_addr == RA_CMD),
        .sts_wr   (bus_wr && bus_addr == RA_STS),
        .ist_wr   (bus_wr && bus_addr == RA_IST),
        .wdata    (bus_wdata),
        .shadow   (shadow),
        .inv_busy (inv_busy),
        .eng_done (eng_done),
        .eng_ovf  (eng_ovf),
        .active   (act_desc),
        .act_cmd  (act_cmd),
        .start    (eng_start),
        .abort    (eng_abort),
        .busy     (st_busy),
        .err      (st_err),
        .ovf      (st_ovf),
        .irq_st   (st_ist)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_STS: begin
                bus_rdata[STS_OVF_BIT]  = st_ovf;
                bus_rdata[STS_BUSY_BIT] = st_busy;
                bus_rdata[STS_ERR_BIT]  = st_err;
            end
            RA_DA:   bus_rdata = pack_opnd(shadow.a);
            RA_DB:   bus_rdata = pack_opnd(shadow.b);
            RA_DC:   bus_rdata = pack_opnd(shadow.c);
            RA_DE:   bus_rdata = pack_expd(shadow.e);
            RA_IST:  bus_rdata[0] = st_ist;
            RA_IEN:  bus_rdata[0] = irq_en;
            default: bus_rdata = '0;
        endcase
    end

    assign eng_op     = act_cmd.op;
    assign eng_exp    = act_cmd.exp;
    assign eng_a_base = act_desc.a.base;
    assign eng_a_len  = act_desc.a.len;
    assign eng_b_base = act_desc.b.base;
    assign eng_b_len  = act_desc.b.len;
    assign eng_c_base = act_desc.c.base;
    assign eng_c_len  = act_desc.c.len;
    assign eng_e_base = act_desc.e.base;
    assign eng_e_bits = act_desc.e.bits;
    assign irq        = st_ist & irq_en;

endmodule

// File: rtl/mae_cmd_front_chk.sv
module mae_cmd_front_chk
    import mae_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              inv_busy,
    input logic              eng_done,
    input logic              eng_start,
    input logic              eng_abort,
    input logic              busy,
    input logic              irq_st,
    input logic [DESC_W-1:0] act_bits
);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R5
    start_helper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(inv_busy));

    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start) |-> $stable(act_bits));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !busy);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_st);

endmodule

bind mae_cmd_front mae_cmd_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_busy  (inv_busy),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .busy      (st_busy),
    .irq_st    (st_ist),
    .act_bits  (act_desc)
);

// File: tb/sim_mae_cmd_front.sv
module sim_mae_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        inv_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_ovf = 1'b0;
    logic        eng_start, eng_abort, eng_exp, irq;
    logic [1:0]  eng_op;
    logic [9:0]  eng_a_base, eng_b_base, eng_c_base;
    logic [7:0]  eng_a_len, eng_b_len, eng_c_len;
    logic [10:0] eng_e_base;
    logic [12:0] eng_e_bits;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mae_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inv_busy(inv_busy),
        .eng_done(eng_done), .eng_ovf(eng_ovf), .eng_start(eng_start),
        .eng_abort(eng_abort), .eng_op(eng_op), .eng_exp(eng_exp),
        .eng_a_base(eng_a_base), .eng_a_len(eng_a_len),
        .eng_b_base(eng_b_base), .eng_b_len(eng_b_len),
        .eng_c_base(eng_c_base), .eng_c_len(eng_c_len),
        .eng_e_base(eng_e_base), .eng_e_bits(eng_e_bits), .irq(irq)
    );

    // reference model state
    bit          m_busy, m_pend, m_err, m_ovf, m_ist, m_ien, m_start, m_abort, m_exp, p_exp;
    bit   [1:0]  m_op, p_op;
    logic [31:0] sh  [2:5];
    logic [31:0] act [2:5];

    function automatic logic [31:0] fld_mask(input int a);
        return (a == 5) ? 32'h1FFF07FF : 32'h00FF03FF;
    endfunction

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_err, m_busy, m_ovf};
            3'd2, 3'd3, 3'd4, 3'd5: return sh[int'(a)];
            3'd6: return {31'd0, m_ist};
            3'd7: return {31'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_err = 0; m_ovf = 0; m_ist = 0; m_ien = 0;
            m_start = 0; m_abort = 0; m_op = 0; m_exp = 0; p_op = 0; p_exp = 0;
            for (int i = 2; i <= 5; i++) begin sh[i] = '0; act[i] = '0; end
        end else begin
            bit o_busy, o_pend, ab, cnz, odd, launch, fall, s_err, s_ovf, l_exp;
            bit [1:0] l_op;
            o_busy = m_busy; o_pend = m_pend;
            m_start = 0; m_abort = 0; launch = 0; fall = 0; s_err = 0; s_ovf = 0;
            l_op = p_op; l_exp = p_exp;
            ab  = bus_wr && bus_addr == 3'd1 && bus_wdata[5];
            cnz = bus_wr && bus_addr == 3'd1 && !bus_wdata[5] && bus_wdata[2:0] != 3'd0;
            odd = sh[2][0] | sh[3][0] | sh[4][0] | sh[5][0];
            if (ab) begin
                m_abort = 1; m_pend = 0;
                if (o_busy) begin m_busy = 0; fall = 1; end
            end else begin
                if (o_busy && eng_done) begin m_busy = 0; fall = 1; s_ovf = eng_ovf; end
                if (o_pend && !inv_busy) begin launch = 1; m_pend = 0; end
                if (cnz) begin
                    if (o_busy || o_pend || odd) s_err = 1;
                    else if (inv_busy) begin m_pend = 1; p_op = bus_wdata[1:0]; p_exp = bus_wdata[2]; end
                    else begin launch = 1; l_op = bus_wdata[1:0]; l_exp = bus_wdata[2]; end
                end
            end
            if (launch) begin
                m_busy = 1; m_start = 1; m_op = l_op; m_exp = l_exp;
                for (int i = 2; i <= 5; i++) act[i] = sh[i];
            end
            if (bus_wr && bus_addr == 3'd0 && bus_wdata[0]) m_ovf = 0;
            if (bus_wr && bus_addr == 3'd0 && bus_wdata[2]) m_err = 0;
            if (s_ovf) m_ovf = 1;
            if (s_err) m_err = 1;
            if (bus_wr && bus_addr == 3'd6 && bus_wdata[0]) m_ist = 0;
            if (fall) m_ist = 1;
            if (bus_wr && bus_addr >= 3'd2 && bus_addr <= 3'd5)
                sh[int'(bus_addr)] = bus_wdata & fld_mask(int'(bus_addr));
            if (bus_wr && bus_addr == 3'd7) m_ien = bus_wdata[0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, a, e, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(eng_start == m_start, "R3 start", 32'(eng_start), 32'(m_start));
            chk(eng_abort == m_abort, "R8 abort", 32'(eng_abort), 32'(m_abort));
            chk({eng_op, eng_exp} == {m_op, m_exp}, "R3 op", 32'({eng_op, eng_exp}), 32'({m_op, m_exp}));
            chk({eng_a_len, eng_a_base, eng_b_len, eng_b_base} ==
                {act[2][23:16], act[2][9:0], act[3][23:16], act[3][9:0]}, "R4 act ab",
                32'({eng_a_base, eng_b_base}), 32'({act[2][9:0], act[3][9:0]}));
            chk({eng_c_len, eng_c_base, eng_e_bits, eng_e_base} ==
                {act[4][23:16], act[4][9:0], act[5][28:16], act[5][10:0]}, "R4 act ce",
                32'({eng_c_base, eng_e_base}), 32'({act[4][9:0], act[5][10:0]}));
            chk(irq == (m_ist & m_ien), "R11 irq", 32'(irq), 32'(m_ist & m_ien));
            chk(bus_rdata == model_rd(bus_addr), "R2 rdata", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); bus_wr = 0; bus_addr = a;
        #1 chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic done_pulse(input bit o);
        @(negedge clk); eng_done = 1; eng_ovf = o;
        @(negedge clk); eng_done = 0; eng_ovf = 0;
    endtask

    initial begin
        #(100000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset read");
        chk(!eng_start && !eng_abort && !irq, "R1 outputs", 32'({eng_start, eng_abort, irq}), 32'd0);

        // R2 field masking
        wr_reg(3'd2, 32'hFFFF_FFFE); rd_chk(3'd2, 32'h00FF_03FE, "R2 opnd fields");
        wr_reg(3'd5, 32'hFFFF_FFFE); rd_chk(3'd5, 32'h1FFF_07FE, "R2 exp fields");
        wr_reg(3'd2, 32'h0005_0010); wr_reg(3'd3, 32'h0003_0020);
        wr_reg(3'd4, 32'h0001_0040); wr_reg(3'd5, 32'h00FF_0100);
        wr_reg(3'd7, 32'd1);

        // R3 launch
        wr_reg(3'd1, 32'd1);
        chk(eng_start == 1, "R3 start pulse", 32'(eng_start), 32'd1);
        chk(eng_a_base == 10'h10, "R3 active base", 32'(eng_a_base), 32'h10);
        rd_chk(3'd0, 32'h2, "R3 busy flag");

        // R4 shadow write while busy
        wr_reg(3'd2, 32'h0007_0030);
        chk(eng_a_base == 10'h10, "R4 active held", 32'(eng_a_base), 32'h10);

        // R7 command while busy
        wr_reg(3'd1, 32'd2);
        rd_chk(3'd0, 32'h6, "R7 error while busy");
        chk(eng_op == 2'd1, "R7 op unchanged", 32'(eng_op), 32'd1);

        // R9 / R11 done
        done_pulse(0);
        rd_chk(3'd0, 32'h4, "R9 busy cleared");
        rd_chk(3'd6, 32'h1, "R11 irq flag");
        chk(irq == 1, "R11 irq out", 32'(irq), 32'd1);

        // R10 clears
        wr_reg(3'd0, 32'h4); wr_reg(3'd6, 32'h1);
        rd_chk(3'd0, 32'h0, "R10 err cleared");

        // R5 deferral, with a shadow write on the launch edge
        @(negedge clk); inv_busy = 1;
        wr_reg(3'd1, 32'h7);
        repeat (3) @(negedge clk);
        chk(eng_start == 0, "R5 held", 32'(eng_start), 32'd0);
        rd_chk(3'd0, 32'h0, "R5 not busy while held");
        @(negedge clk); inv_busy = 0; bus_wr = 1; bus_addr = 3'd3; bus_wdata = 32'h0002_0050;
        @(negedge clk); bus_wr = 0; #1;
        chk(eng_start == 1, "R5 launch after helper", 32'(eng_start), 32'd1);
        chk(eng_b_base == 10'h20, "R4 old shadow on launch edge", 32'(eng_b_base), 32'h20);
        chk({eng_op, eng_exp} == 3'b111, "R3 op3 exp", 32'({eng_op, eng_exp}), 32'h7);
        rd_chk(3'd3, 32'h0002_0050, "R4 new shadow kept");

        // R10 overflow set beats clear
        @(negedge clk); eng_done = 1; eng_ovf = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'h1;
        @(negedge clk); eng_done = 0; eng_ovf = 0; bus_wr = 0;
        rd_chk(3'd0, 32'h1, "R10 ovf set wins");
        wr_reg(3'd0, 32'h1); wr_reg(3'd6, 32'h1);
        rd_chk(3'd0, 32'h0, "R10 ovf cleared");

        // R6 odd base
        wr_reg(3'd4, 32'h0001_0041);
        wr_reg(3'd1, 32'd1);
        chk(eng_start == 0, "R6 no launch", 32'(eng_start), 32'd0);
        rd_chk(3'd0, 32'h4, "R6 error flag");
        wr_reg(3'd4, 32'h0001_0040); wr_reg(3'd0, 32'h4);

        // R8 abort running
        wr_reg(3'd1, 32'd1);
        wr_reg(3'd1, 32'h21);
        chk(eng_abort == 1, "R8 abort pulse", 32'(eng_abort), 32'd1);
        rd_chk(3'd0, 32'h0, "R8 busy cleared");
        rd_chk(3'd6, 32'h1, "R11 irq on abort");
        wr_reg(3'd6, 32'h1);

        // R8 abort while pending
        @(negedge clk); inv_busy = 1;
        wr_reg(3'd1, 32'd2);
        wr_reg(3'd1, 32'h20);
        @(negedge clk); inv_busy = 0;
        repeat (3) @(negedge clk);
        rd_chk(3'd0, 32'h0, "R8 pending dropped");

        // R3 no-op, R9 done while idle
        wr_reg(3'd1, 32'd0);
        rd_chk(3'd0, 32'h0, "R3 no-op");
        done_pulse(1);
        rd_chk(3'd0, 32'h0, "R9 idle done ignored");

        // R11 masked interrupt
        wr_reg(3'd7, 32'd0);
        wr_reg(3'd1, 32'd2);
        done_pulse(0);
        rd_chk(3'd6, 32'h1, "R11 flag set");
        chk(irq == 0, "R11 masked", 32'(irq), 32'd0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule